// File: doc/BRIEF.md
# Boot Source Signature Detector

This block runs once after reset and picks where an embedded processor takes its code from. It reads a four-byte ASCII signature from an external serial flash. If the signature is not there, it reads two four-byte signatures from a serial configuration EEPROM. The result is one of three outcomes: boot from the external flash, boot from the internal ROM with the EEPROM's configuration, or boot from the internal ROM with default settings. It also reports the address where fetching starts.

The serial bus engines sit outside this block. Each memory is reached through a simple byte-read port. The block raises a one-cycle request with an address, and the engine answers with an acknowledge strobe and a data byte some cycles later. A memory that is not fitted never answers. A bounded wait turns that case into a failed match, so the block does not hang. The verdict appears with a single done pulse and then holds until the next reset.

Top module: `boot_sig_detect`

## Requirements
- R1: After reset the flash is probed first. The EEPROM port issues no request until the flash check has failed, and issues none at all when the flash check succeeds.
- R2: The flash check passes only when addresses 0x00FFFA, 0x00FFFB, 0x00FFFC and 0x00FFFD return 0x32, 0x44, 0x46 and 0x55 ("2DFU") in that order.
- R3: When the flash check passes, boot_src becomes 2'b01 and boot_addr becomes 0x000000.
- R4: When the flash check fails, the EEPROM is probed for 0x41 0x54 0x41 0x32 ("ATA2") at 0x00FC..0x00FF. If that matches, it is then probed for 0x65 0x63 0x66 0x31 ("ecf1") at 0x017C..0x017F.
- R5: When both EEPROM signatures match, boot_src becomes 2'b10 and boot_addr becomes 0xFF0000 (internal ROM start).
- R6: When either EEPROM signature fails after a flash failure, boot_src becomes 2'b11 and boot_addr becomes 0xFF0000.
- R7: Signature bytes are read in increasing address order, one request per byte. A probe stops at its first mismatching byte, and a failed first EEPROM signature means the second one is not read.
- R8: A byte that is acknowledged within TIMEOUT (64) cycles after its request is used. A byte whose acknowledge comes later, or never comes, counts as a mismatch.
- R9: While reset is held and until the verdict, boot_src is 2'b00 and boot_done is low. boot_done pulses high for exactly one cycle, and boot_src and boot_addr then stay constant until the next reset.
- R10: Each read request is high for one cycle only, with at most one read outstanding per port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flash_req | output | 1 | One-cycle flash byte read request |
| flash_addr | output | 24 | Flash byte address, valid with flash_req |
| flash_ack | input | 1 | Flash read data strobe |
| flash_data | input | 8 | Flash read byte, valid with flash_ack |
| eep_req | output | 1 | One-cycle EEPROM byte read request |
| eep_addr | output | 16 | EEPROM byte offset, valid with eep_req |
| eep_ack | input | 1 | EEPROM read data strobe |
| eep_data | input | 8 | EEPROM read byte, valid with eep_ack |
| boot_src | output | 2 | 00 pending, 01 flash, 10 ROM with EEPROM config, 11 ROM defaults |
| boot_done | output | 1 | One-cycle pulse when the verdict is set |
| boot_addr | output | 24 | Start fetch address, valid from boot_done |

## Verification
A wrong byte index or base register shows up at once at the read ports. The address sequence drifts away from base, base+1, base+2, base+3, or the number of reads differs from the count set by the first mismatching byte. A corrupt phase or comparison does not show until the verdict. The boot_src code or the start address is then wrong, and the result appears at most one probe's duration late. A broken timeout counter shows as a missing done pulse after a device that never answers, or as a wrong outcome when an answer arrives on the last allowed cycle.

// File: rtl/boot_sig_pkg.sv
package boot_sig_pkg;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'b00,
    SRC_FLASH   = 2'b01,
    SRC_ROM_CFG = 2'b10,
    SRC_ROM_DEF = 2'b11
  } boot_src_e;

  localparam int SIG_BYTES = 4;

  // byte idx of a packed signature; the first byte sits in the top lane
  function automatic logic [7:0] sig_byte(input logic [31:0] sig, input logic [1:0] idx);
    return sig[8*(SIG_BYTES-1-int'(idx)) +: 8];
  endfunction

  function automatic boot_src_e rom_outcome(input logic cfg_ok);
    return cfg_ok ? SRC_ROM_CFG : SRC_ROM_DEF;
  endfunction

endpackage

// File: rtl/sig_probe.sv
module sig_probe
  import boot_sig_pkg::*;
#(
  parameter int AW      = 16,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [31:0]   sig,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          fin,
  output logic          hit
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  typedef enum logic [1:0] {PR_IDLE, PR_ISSUE, PR_WAIT} pst_e;

  pst_e          st;
  logic [1:0]    idx;
  logic [TW-1:0] timer;
  logic [AW-1:0] base_q;
  logic [31:0]   sig_q;
  logic          fin_q, hit_q;

  // named events for the assertions
  logic got, byte_eq, last, expired, step_ok, finish;
  assign got     = (st == PR_WAIT) && rd_ack;
  assign byte_eq = (rd_data == sig_byte(sig_q, idx));
  assign last    = (idx == 2'(SIG_BYTES - 1));
  assign expired = (st == PR_WAIT) && !rd_ack && (timer == TLAST);
  assign step_ok = got && byte_eq && !last;
  assign finish  = expired || (got && (!byte_eq || last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PR_IDLE;
      idx    <= '0;
      timer  <= '0;
      base_q <= '0;
      sig_q  <= '0;
      fin_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      fin_q <= finish;
      if (finish) hit_q <= got && byte_eq && last;
      unique case (st)
        PR_IDLE: if (start) begin
          base_q <= base;
          sig_q  <= sig;
          idx    <= '0;
          st     <= PR_ISSUE;
        end
        PR_ISSUE: begin
          timer <= '0;
          st    <= PR_WAIT;
        end
        PR_WAIT: begin
          if (finish) begin
            st <= PR_IDLE;
          end else if (step_ok) begin
            idx <= idx + 2'd1;
            st  <= PR_ISSUE;
          end else begin
            timer <= timer + TW'(1);
          end
        end
        default: st <= PR_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == PR_ISSUE);
  assign rd_addr = base_q + AW'(idx);
  assign fin     = fin_q;
  assign hit     = hit_q;

  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r7_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok |=> (rd_req && rd_addr == $past(rd_addr) + AW'(1)));
  a_r8_expire_miss: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (fin && !hit));
  a_r7_miss_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (got && !byte_eq) |=> (fin && !hit && !rd_req));

endmodule

// File: rtl/boot_sig_detect.sv
module boot_sig_detect
  import boot_sig_pkg::*;
#(
  parameter int          FLASH_AW    = 24,
  parameter int          EEP_AW      = 16,
  parameter int          TIMEOUT     = 64,
  parameter logic [23:0] FLASH_BASE  = 24'h00FFFA,
  parameter logic [31:0] FLASH_SIG   = 32'h32444655,
  parameter logic [15:0] CFG1_BASE   = 16'h00FC,
  parameter logic [31:0] CFG1_SIG    = 32'h41544132,
  parameter logic [15:0] CFG2_BASE   = 16'h017C,
  parameter logic [31:0] CFG2_SIG    = 32'h65636631,
  parameter logic [23:0] EXT_START   = 24'h000000,
  parameter logic [23:0] ROM_START   = 24'hFF0000
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                flash_req,
  output logic [FLASH_AW-1:0] flash_addr,
  input  logic                flash_ack,
  input  logic [7:0]          flash_data,
  output logic                eep_req,
  output logic [EEP_AW-1:0]   eep_addr,
  input  logic                eep_ack,
  input  logic [7:0]          eep_data,
  output logic [1:0]          boot_src,
  output logic                boot_done,
  output logic [23:0]         boot_addr
);

  typedef enum logic [1:0] {PH_FLASH, PH_CFG1, PH_CFG2, PH_END} phase_e;

  phase_e    ph;
  logic      kick;
  boot_src_e src_q;
  logic [23:0] addr_q;
  logic      done_q;

  logic f_fin, f_hit, e_fin, e_hit;
  logic f_start, e_start;
  logic [EEP_AW-1:0] e_base;
  logic [31:0]       e_sig;

  assign f_start = kick && (ph == PH_FLASH);
  assign e_start = kick && (ph == PH_CFG1 || ph == PH_CFG2);
  assign e_base  = (ph == PH_CFG2) ? EEP_AW'(CFG2_BASE) : EEP_AW'(CFG1_BASE);
  assign e_sig   = (ph == PH_CFG2) ? CFG2_SIG : CFG1_SIG;

  sig_probe #(.AW(FLASH_AW), .TIMEOUT(TIMEOUT)) u_flash_probe (
    .clk(clk), .rst_n(rst_n), .start(f_start),
    .base(FLASH_AW'(FLASH_BASE)), .sig(FLASH_SIG),
    .rd_req(flash_req), .rd_addr(flash_addr),
    .rd_ack(flash_ack), .rd_data(flash_data),
    .fin(f_fin), .hit(f_hit)
  );

  sig_probe #(.AW(EEP_AW), .TIMEOUT(TIMEOUT)) u_eep_probe (
    .clk(clk), .rst_n(rst_n), .start(e_start),
    .base(e_base), .sig(e_sig),
    .rd_req(eep_req), .rd_addr(eep_addr),
    .rd_ack(eep_ack), .rd_data(eep_data),
    .fin(e_fin), .hit(e_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_FLASH;
      kick   <= 1'b1;
      src_q  <= SRC_NONE;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      kick   <= 1'b0;
      done_q <= 1'b0;
      unique case (ph)
        PH_FLASH: if (f_fin) begin
          if (f_hit) begin
            ph     <= PH_END;
            src_q  <= SRC_FLASH;
            addr_q <= EXT_START;
            done_q <= 1'b1;
          end else begin
            ph   <= PH_CFG1;
            kick <= 1'b1;
          end
        end
        PH_CFG1: if (e_fin) begin
          if (e_hit) begin
            ph   <= PH_CFG2;
            kick <= 1'b1;
          end else begin
            ph     <= PH_END;
            src_q  <= SRC_ROM_DEF;
            addr_q <= ROM_START;
            done_q <= 1'b1;
          end
        end
        PH_CFG2: if (e_fin) begin
          ph     <= PH_END;
          src_q  <= rom_outcome(e_hit);
          addr_q <= ROM_START;
          done_q <= 1'b1;
        end
        default: ph <= PH_END;
      endcase
    end
  end

  assign boot_src  = src_q;
  assign boot_addr = addr_q;
  assign boot_done = done_q;

  a_r1_flash_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FLASH) |-> !eep_req);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_END && !boot_done) |-> ($stable(boot_src) && $stable(boot_addr)));
  a_r9_pending_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_END) |-> (boot_src == SRC_NONE && !boot_done));
  a_r3_flash_start: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && boot_src == SRC_FLASH) |-> (boot_addr == EXT_START));
  a_r1_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_END) |-> (!flash_req && !eep_req));

endmodule

// File: tb/boot_sig_detect_tb.sv
module boot_sig_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flash_req, eep_req, boot_done;
  logic [23:0] flash_addr, boot_addr;
  logic [15:0] eep_addr;
  logic flash_ack = 1'b0, eep_ack = 1'b0;
  logic [7:0] flash_data = 8'h00, eep_data = 8'h00;
  logic [1:0] boot_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sig_detect u_dut (
    .clk(clk), .rst_n(rst_n),
    .flash_req(flash_req), .flash_addr(flash_addr), .flash_ack(flash_ack), .flash_data(flash_data),
    .eep_req(eep_req), .eep_addr(eep_addr), .eep_ack(eep_ack), .eep_data(eep_data),
    .boot_src(boot_src), .boot_done(boot_done), .boot_addr(boot_addr)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // memory models configured per case
  bit f_present, e_present;
  int lat;
  logic [31:0] f_sig, e_sig1, e_sig2;
  int f_reads, e_reads, f_cnt, e_cnt;
  logic [23:0] f_aq;
  logic [15:0] e_aq;
  bit f_prev, e_prev;

  function automatic logic [7:0] pick(input logic [31:0] s, input int i);
    return s[8*(3-i) +: 8];
  endfunction
  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    if (a >= 24'h00FFFA && a <= 24'h00FFFD) return pick(f_sig, int'(a - 24'h00FFFA));
    return 8'hFF;
  endfunction
  function automatic logic [7:0] eep_byte(input logic [15:0] a);
    if (a >= 16'h00FC && a <= 16'h00FF) return pick(e_sig1, int'(a - 16'h00FC));
    if (a >= 16'h017C && a <= 16'h017F) return pick(e_sig2, int'(a - 16'h017C));
    return 8'hFF;
  endfunction
  function automatic logic [15:0] eep_expect_addr(input int n);
    return (n < 4) ? 16'(16'h00FC + n) : 16'(16'h017C + n - 4);
  endfunction

  always @(posedge clk) begin
    flash_ack <= 1'b0;
    if (!rst_n) begin
      f_cnt <= 0; f_prev <= 1'b0;
    end else begin
      f_prev <= flash_req;
      if (flash_req) begin
        chk(!f_prev, "R10", "flash req width", 2, 1);
        chk(flash_addr == 24'(24'h00FFFA + f_reads), "R7", "flash read addr",
            flash_addr, 24'h00FFFA + f_reads);
        f_reads <= f_reads + 1;
        f_aq <= flash_addr;
        if (f_present) begin
          if (lat == 0) begin flash_ack <= 1'b1; flash_data <= flash_byte(flash_addr); end
          else f_cnt <= lat;
        end
      end else if (f_cnt > 0) begin
        if (f_cnt == 1) begin flash_ack <= 1'b1; flash_data <= flash_byte(f_aq); end
        f_cnt <= f_cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    eep_ack <= 1'b0;
    if (!rst_n) begin
      e_cnt <= 0; e_prev <= 1'b0;
    end else begin
      e_prev <= eep_req;
      if (eep_req) begin
        chk(!e_prev, "R10", "eeprom req width", 2, 1);
        chk(eep_addr == eep_expect_addr(e_reads), "R4", "eeprom read addr",
            eep_addr, eep_expect_addr(e_reads));
        e_reads <= e_reads + 1;
        e_aq <= eep_addr;
        if (e_present) begin
          if (lat == 0) begin eep_ack <= 1'b1; eep_data <= eep_byte(eep_addr); end
          else e_cnt <= lat;
        end
      end else if (e_cnt > 0) begin
        if (e_cnt == 1) begin eep_ack <= 1'b1; eep_data <= eep_byte(e_aq); end
        e_cnt <= e_cnt - 1;
      end
    end
  end

  // scoreboard
  typedef struct packed { logic [1:0] src; logic [23:0] addr; } verdict_t;
  verdict_t exp_q[$];
  int done_cnt;

  always @(negedge clk) begin
    if (rst_n && boot_done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        verdict_t e;
        e = exp_q.pop_front();
        chk(boot_src == e.src, "R3 R5 R6", "boot_src", boot_src, e.src);
        chk(boot_addr == e.addr, "R3 R5 R6", "boot_addr", boot_addr, e.addr);
      end
    end
  end

  function automatic int reads_for(input bit present, input logic [31:0] got,
                                   input logic [31:0] want, output bit ok);
    ok = 1'b0;
    if (!present || lat >= TMO) return 1;
    for (int i = 0; i < 4; i++)
      if (pick(got, i) != pick(want, i)) return i + 1;
    ok = 1'b1;
    return 4;
  endfunction

  task automatic run_case(input string name);
    bit fok, ok1, ok2;
    int nf, ne;
    verdict_t v;
    logic [1:0] s0; logic [23:0] a0;
    nf = reads_for(f_present, f_sig, 32'h32444655, fok);
    ne = 0;
    if (fok) begin
      v.src = 2'b01; v.addr = 24'h000000;
    end else begin
      ne = reads_for(e_present, e_sig1, 32'h41544132, ok1);
      ok2 = 1'b0;
      if (ok1) ne += reads_for(e_present, e_sig2, 32'h65636631, ok2);
      v.src = (ok1 && ok2) ? 2'b10 : 2'b11;
      v.addr = 24'hFF0000;
    end
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(boot_src == 2'b00 && !boot_done, "R9", {name, " reset state"}, {boot_src, boot_done}, 0);
    chk(!flash_req && !eep_req, "R10", {name, " no req in reset"}, {flash_req, eep_req}, 0);
    f_reads = 0; e_reads = 0; done_cnt = 0;
    exp_q.push_back(v);
    rst_n = 1'b1;
    for (int i = 0; i < 1000 && done_cnt == 0; i++) @(negedge clk);
    chk(done_cnt == 1, "R9", {name, " done seen"}, done_cnt, 1);
    s0 = boot_src; a0 = boot_addr;
    repeat (12) @(negedge clk);
    chk(done_cnt == 1 && boot_src == s0 && boot_addr == a0, "R9", {name, " held"},
        {boot_src, boot_addr}, {s0, a0});
    chk(f_reads == nf, "R7", {name, " flash reads"}, f_reads, nf);
    chk(e_reads == ne, fok ? "R1" : "R7", {name, " eeprom reads"}, e_reads, ne);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R2 R3: valid flash
    f_present = 1; f_sig = 32'h32444655; e_present = 1;
    e_sig1 = 32'h41544132; e_sig2 = 32'h65636631; lat = 3;
    run_case("R2 flash ok");
    // R4 R5: flash absent, both eeprom signatures
    f_present = 0; lat = 2;
    run_case("R5 cfg ok");
    // R6: second signature last byte wrong
    f_present = 1; f_sig = 32'h00444655; e_sig2 = 32'h65636630;
    run_case("R6 cfg2 bad");
    // R7: flash miss at byte 2, eeprom sig1 miss at byte 1
    f_sig = 32'h32445855; e_sig1 = 32'h41004132; e_sig2 = 32'h65636631;
    run_case("R7 early stop");
    // R6 R8: nothing fitted
    f_present = 0; e_present = 0;
    run_case("R8 both absent");
    // R8: acknowledge on the last allowed cycle
    f_present = 1; e_present = 1; f_sig = 32'h32444655; e_sig1 = 32'h41544132;
    lat = TMO - 1;
    run_case("R8 late ok");
    // R8: acknowledge one cycle too late
    lat = TMO;
    run_case("R8 too late");
    // R3: zero latency
    lat = 0;
    run_case("R3 fast");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule